// File: doc/BRIEF.md
# Page Access Fault Checker

This block sits beside the CPU bus and judges every memory access against the status entry of the page being touched and against the privilege of the running code. The page entry comes in with three bits: write enable, and a two-bit usage state (high and low state bits). The storage that holds these entries is outside the block. When an access breaks a rule, the block raises a fault pulse in the same cycle and records why. It keeps three 16-bit status words: a general status code, a bus status word that holds the transfer shape and the top address byte, and a second bus status word that holds the low address half.

When an access in the RAM window is allowed, the block proposes a new page entry and raises a write-back strobe in the same cycle, so that the map storage can record that the page was referenced and, for writes, modified. A faulting access leaves the entry alone. Software resets the three status words to all ones by pulsing a clear strobe.

Top module: `pg_fault_chk`

## Requirements
- R1: Page checks that read the usage state, and every page write-back, apply only to addresses 0x000000 to 0x3FFFFF; `pg_wb` is never raised above 0x3FFFFF.
- R2: A RAM-window access whose usage state bits `pg_bits[1:0]` are both 0 (page absent) faults in every mode and takes precedence over every other rule; its general code is 0x8BFF for a write and 0xCBFF for a read.
- R3: When supervisor mode is off (bit 13 of `cpu_sr` is 0), any access to 0x000000 to 0x07FFFF faults with general code 0x9BFF (write) or 0xDBFF (read); with bit 13 set, no rule other than R2 applies.
- R4: In user mode, a write to a RAM-window page whose write-enable bit `pg_bits[2]` is 0 faults with code 0x9BFF; a read of such a page does not fault by this rule.
- R5: In user mode, any access to 0x400000 to 0xFFFFFF faults with general code 0x9AFF (write) or 0xDAFF (read).
- R6: When `pie` is 1 during a faulting access, bit 10 (0x0400) is also set in the stored general code.
- R7: On a fault, the first bus status word becomes 0x7C00 for word (`size`=01) or long (`size`=10 or 11) transfers, 0x7E00 for a byte (`size`=00) at an odd address and 0x7D00 for a byte at an even address, with address bits 23:16 in its low byte.
- R8: On a fault, the second bus status word becomes address bits 15:0.
- R9: On an allowed RAM-window access, `pg_wb` is 1 and `pg_new` keeps the write-enable bit, sets the high state bit, and sets the low state bit only when the old state was 11, or the access is a write and the old state was 01 or 10; otherwise the low state bit is 0.
- R10: On a faulting access `pg_wb` is 0 and `pg_new` equals `pg_bits`, so an absent page never gains the high state bit.
- R11: Reset and a `clr_stb` pulse set all three status words to 0xFFFF; when a fault and a clear fall in the same cycle, the fault values are stored.
- R12: `fault`, `pg_wb` and `pg_new` respond in the cycle of `acc_stb` and `fault` is 0 whenever `acc_stb` is 0; the status words change at the clock edge ending a faulting or clearing cycle and otherwise hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_stb | input | 1 | One cycle per bus access |
| addr | input | 24 | Access address |
| size | input | 2 | 00 byte, 01 word, 10/11 long |
| wr | input | 1 | 1 for a write, 0 for a read |
| cpu_sr | input | 16 | Processor status word; bit 13 is supervisor |
| pg_bits | input | 3 | Current page entry: [2] write enable, [1] high state, [0] low state |
| pie | input | 1 | Interrupt-enable flag folded into the general code |
| clr_stb | input | 1 | Clears the status words to all ones |
| fault | output | 1 | Access fault, same cycle as `acc_stb` |
| pg_wb | output | 1 | Write-back strobe for the page entry |
| pg_new | output | 3 | Page entry to write back |
| gen_stat | output | 16 | General status word |
| bus_st0 | output | 16 | Transfer shape and address bits 23:16 |
| bus_st1 | output | 16 | Address bits 15:0 |

## Verification
The fault pulse, the write-back strobe and the proposed page entry are combinational in the access cycle, so the bench drives each access just after a falling edge and samples those three outputs a quarter period later, before the next rising edge. The three status words are registered once, so they are checked one time unit after the rising edge that ends the access cycle, and again after a following idle cycle to confirm they hold. The sweep covers every page entry, mode, direction, size and interrupt-enable value at addresses on both sides of each region boundary and at both byte parities.

// File: rtl/pg_fault_chk.sv
module pg_fault_chk #(
  parameter logic [23:0] RAM_TOP  = 24'h3FFFFF,
  parameter logic [23:0] KERN_TOP = 24'h07FFFF,
  parameter logic [23:0] IO_BASE  = 24'h400000,
  parameter int          SUP_BIT  = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_stb,
  input  logic [23:0] addr,
  input  logic [1:0]  size,
  input  logic        wr,
  input  logic [15:0] cpu_sr,
  input  logic [2:0]  pg_bits,
  input  logic        pie,
  input  logic        clr_stb,
  output logic        fault,
  output logic        pg_wb,
  output logic [2:0]  pg_new,
  output logic [15:0] gen_stat,
  output logic [15:0] bus_st0,
  output logic [15:0] bus_st1
);
  localparam logic [15:0] ALL_ONES = 16'hFFFF;

  logic sup, in_ram, present;
  logic f_absent, f_kern, f_wprot, f_io, any_fault;
  logic next_ps0;
  logic [15:0] code, shape;
  logic [15:0] unused_sr;

  assign unused_sr = cpu_sr & ~(16'h1 << SUP_BIT);
  assign sup       = cpu_sr[SUP_BIT];
  assign in_ram    = addr <= RAM_TOP;
  assign present   = |pg_bits[1:0];

  assign f_absent  = in_ram & ~present;
  assign f_kern    = ~sup & (addr <= KERN_TOP);
  assign f_wprot   = ~sup & wr & in_ram & ~pg_bits[2];
  assign f_io      = ~sup & (addr >= IO_BASE);
  assign any_fault = f_absent | f_kern | f_wprot | f_io;

  assign fault = acc_stb & any_fault;
  assign pg_wb = acc_stb & in_ram & ~any_fault;

  assign next_ps0 = (pg_bits[1:0] == 2'b11) |
                    (wr & (pg_bits[1] ^ pg_bits[0]));
  assign pg_new   = pg_wb ? {pg_bits[2], 1'b1, next_ps0} : pg_bits;

  always_comb begin
    if (f_absent)              code = wr ? 16'h8BFF : 16'hCBFF;
    else if (f_kern | f_wprot) code = wr ? 16'h9BFF : 16'hDBFF;
    else                       code = wr ? 16'h9AFF : 16'hDAFF;
    if (pie) code = code | 16'h0400;
  end

  always_comb begin
    if (size != 2'b00)  shape = 16'h7C00;
    else if (addr[0])   shape = 16'h7E00;
    else                shape = 16'h7D00;
    shape[7:0] = addr[23:16];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_stat <= ALL_ONES;
      bus_st0  <= ALL_ONES;
      bus_st1  <= ALL_ONES;
    end else if (fault) begin
      gen_stat <= code;
      bus_st0  <= shape;
      bus_st1  <= addr[15:0];
    end else if (clr_stb) begin
      gen_stat <= ALL_ONES;
      bus_st0  <= ALL_ONES;
      bus_st1  <= ALL_ONES;
    end
  end
endmodule

// File: rtl/pg_fault_chk_sva.sv
module pg_fault_chk_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_stb,
  input logic [23:0] addr,
  input logic        sup,
  input logic [2:0]  pg_bits,
  input logic        clr_stb,
  input logic        fault,
  input logic        pg_wb,
  input logic [2:0]  pg_new,
  input logic [15:0] gen_stat,
  input logic [15:0] bus_st0,
  input logic [15:0] bus_st1
);
  p_wb_ram_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pg_wb |-> addr <= 24'h3FFFFF);

  p_absent_faults_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && addr <= 24'h3FFFFF && pg_bits[1:0] == 2'b00) |-> fault);

  p_super_present_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && sup && addr <= 24'h3FFFFF && pg_bits[1:0] != 2'b00) |-> !fault);

  p_bsr1_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> bus_st1 == $past(addr[15:0]));

  p_wb_marks_used_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pg_wb |-> (pg_new[1] && pg_new[2] == pg_bits[2]));

  p_fault_keeps_page_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!pg_wb && pg_new == pg_bits));

  p_clear_ones_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !fault) |=> (gen_stat == 16'hFFFF && bus_st0 == 16'hFFFF && bus_st1 == 16'hFFFF));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault && !clr_stb) |=> ($stable(gen_stat) && $stable(bus_st0) && $stable(bus_st1)));

  p_no_stb_no_fault_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_stb |-> (!fault && !pg_wb));
endmodule

bind pg_fault_chk pg_fault_chk_sva u_sva (
  .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .addr(addr),
  .sup(cpu_sr[13]), .pg_bits(pg_bits), .clr_stb(clr_stb),
  .fault(fault), .pg_wb(pg_wb), .pg_new(pg_new),
  .gen_stat(gen_stat), .bus_st0(bus_st0), .bus_st1(bus_st1)
);

// File: tb/tb_pg_fault_chk.sv
module tb_pg_fault_chk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_stb = 1'b0;
  logic [23:0] addr = '0;
  logic [1:0]  size = '0;
  logic        wr = 1'b0;
  logic [15:0] cpu_sr = 16'h2000;
  logic [2:0]  pg_bits = '0;
  logic        pie = 1'b0;
  logic        clr_stb = 1'b0;
  logic        fault, pg_wb;
  logic [2:0]  pg_new;
  logic [15:0] gen_stat, bus_st0, bus_st1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [15:0] eg = 16'hFFFF, e0 = 16'hFFFF, e1 = 16'hFFFF;

  always #10 clk = ~clk;

  pg_fault_chk dut (
    .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .addr(addr), .size(size),
    .wr(wr), .cpu_sr(cpu_sr), .pg_bits(pg_bits), .pie(pie), .clr_stb(clr_stb),
    .fault(fault), .pg_wb(pg_wb), .pg_new(pg_new),
    .gen_stat(gen_stat), .bus_st0(bus_st0), .bus_st1(bus_st1)
  );

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (addr=%h wr=%0b sr=%h pg=%b size=%0d pie=%0b)",
               req, act, exp, addr, wr, cpu_sr, pg_bits, size, pie);
    end
  endtask

  task automatic check_regs(input string req);
    chk(gen_stat == eg, {req, " general status"}, {8'h0, gen_stat}, {8'h0, eg});
    chk(bus_st0 == e0, {req, " bus status 0"}, {8'h0, bus_st0}, {8'h0, e0});
    chk(bus_st1 == e1, {req, " bus status 1"}, {8'h0, bus_st1}, {8'h0, e1});
  endtask

  task automatic do_acc(input logic [23:0] a, input logic [1:0] sz, input logic w,
                        input logic s, input logic [2:0] pb, input logic pe, input logic clr);
    logic ram, fa, wbx, ps0n;
    logic [15:0] g, b0;
    logic [2:0] nb;
    string tag;
    ram = (a <= 24'h3FFFFF);
    fa = 1'b0; g = 16'h0; tag = "R3";
    if (ram && pb[1:0] == 2'b00) begin
      fa = 1'b1; g = w ? 16'h8BFF : 16'hCBFF; tag = "R2";
    end else if (!s && a <= 24'h07FFFF) begin
      fa = 1'b1; g = w ? 16'h9BFF : 16'hDBFF; tag = "R3";
    end else if (!s && w && ram && !pb[2]) begin
      fa = 1'b1; g = 16'h9BFF; tag = "R4";
    end else if (!s && a >= 24'h400000) begin
      fa = 1'b1; g = w ? 16'h9AFF : 16'hDAFF; tag = "R5";
    end else if (!s && !w && ram && !pb[2]) begin
      tag = "R4";
    end
    if (pe) g = g | 16'h0400;
    b0 = (sz != 2'b00) ? 16'h7C00 : (a[0] ? 16'h7E00 : 16'h7D00);
    b0[7:0] = a[23:16];
    ps0n = (pb[1:0] == 2'b11) || (w && (pb[1:0] == 2'b01 || pb[1:0] == 2'b10));
    wbx = ram && !fa;
    nb = wbx ? {pb[2], 1'b1, ps0n} : pb;

    @(negedge clk);
    acc_stb = 1'b1; addr = a; size = sz; wr = w;
    cpu_sr = s ? 16'h2000 : 16'hDFFF;
    pg_bits = pb; pie = pe; clr_stb = clr;
    #5;
    chk(fault == fa, {tag, " fault"}, {23'h0, fault}, {23'h0, fa});
    chk(pg_wb == wbx, wbx ? "R9 write-back" : (ram ? "R10 write-back" : "R1 write-back"),
        {23'h0, pg_wb}, {23'h0, wbx});
    chk(pg_new == nb, wbx ? "R9 new page bits" : "R10 new page bits", {21'h0, pg_new}, {21'h0, nb});
    @(posedge clk);
    #1;
    acc_stb = 1'b0; clr_stb = 1'b0;
    if (fa) begin
      eg = g; e0 = b0; e1 = a[15:0];
    end else if (clr) begin
      eg = 16'hFFFF; e0 = 16'hFFFF; e1 = 16'hFFFF;
    end
    if (fa) begin
      chk(gen_stat == eg, pe ? {"R6 ", tag, " code"} : {tag, " code"}, {8'h0, gen_stat}, {8'h0, eg});
      chk(bus_st0 == e0, "R7 shape word", {8'h0, bus_st0}, {8'h0, e0});
      chk(bus_st1 == e1, "R8 low address", {8'h0, bus_st1}, {8'h0, e1});
    end else begin
      check_regs(clr ? "R11" : "R12 hold after allowed access");
    end
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    #5;
    chk(fault == 1'b0 && pg_wb == 1'b0, "R12 idle outputs", {22'h0, fault, pg_wb}, 24'h0);
    @(posedge clk);
    #1;
    check_regs("R12 idle hold");
  endtask

  initial begin
    logic [23:0] alist [8];
    alist[0] = 24'h012344; alist[1] = 24'h07FFFF; alist[2] = 24'h080000; alist[3] = 24'h1A0003;
    alist[4] = 24'h3FFFFF; alist[5] = 24'h400000; alist[6] = 24'h9ABC01; alist[7] = 24'hFFFFFE;
    #35;
    check_regs("R11 reset");
    rst_n = 1'b1;
    for (int ai = 0; ai < 8; ai++)
      for (int sz = 0; sz < 3; sz++)
        for (int w = 0; w < 2; w++)
          for (int s = 0; s < 2; s++)
            for (int pb = 0; pb < 8; pb++)
              for (int pe = 0; pe < 2; pe++) begin
                do_acc(alist[ai], sz[1:0], w[0], s[0], pb[2:0], pe[0], 1'b0);
                if (pb == 0 || pb == 5) idle_cycle();
              end
    do_acc(24'h500000, 2'b11, 1'b0, 1'b0, 3'b111, 1'b0, 1'b0);
    do_acc(24'h200000, 2'b01, 1'b0, 1'b1, 3'b011, 1'b0, 1'b1);
    idle_cycle();
    do_acc(24'h123457, 2'b00, 1'b1, 1'b1, 3'b000, 1'b1, 1'b1);
    do_acc(24'hC00000, 2'b00, 1'b0, 1'b1, 3'b000, 1'b0, 1'b1);
    idle_cycle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R12 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule